// File: doc/BRIEF.md
# Three-Die Random Roller

This block rolls three six-sided dice when a roll request arrives. A 20-bit linear-feedback shift register supplies the random bits. For each attempt the register is clocked eight times and the top eight stages are read as a candidate. A candidate of 216 or more is thrown away and a new batch of eight shifts is made. Because 216 = 6^3, an accepted value in 0..215 maps one-to-one onto the three dice, so the joint result is exactly uniform.

The accepted value is split into three base-6 digits. Each die face is latched as its digit plus one. Each face also drives a seven-LED pip pattern. A one-cycle done pulse marks every new result. The request input is expected to be a synchronised, debounced one-cycle pulse. Requests that arrive while a roll is in progress are ignored.

Top module: `dice_roller`

## Requirements
- R1: While reset is high and after it is released, all LED outputs are 0, all face outputs are 0 and done_o is 0, until the first accepted roll.
- R2: The random source is a 20-bit register with stages 1..20 held in bits 0..19. It resets to 20'h5A5A5. Each shift moves bits toward the MSB and loads stage 20 XOR stage 17 into bit 0. It never holds all zeros; a zero state is reloaded with the seed.
- R3: A roll attempt makes exactly 8 shifts and then reads bits 19:12 as the 8-bit candidate. No other register holds the candidate. The register does not shift outside attempts.
- R4: A candidate greater than 215 is discarded and a further 8 shifts are made, until a candidate of 215 or less appears. With k rejections, done_o is high in the (10 + 9k)-th clock cycle after the edge that samples the request.
- R5: For an accepted value v, die 0 = v mod 6, die 1 = (v/6) mod 6 and die 2 = v/36. Die i is output as digit+1 on faces_o[3i+2:3i].
- R6: Die i drives leds_o[7i+6:7i] with bit order {TL,TR,ML,C,MR,BL,BR} (TL in bit 6). Face 1 = 0001000, 2 = 1000001, 3 = 1001001, 4 = 1100011, 5 = 1101011, 6 = 1110111.
- R7: done_o is high for exactly one cycle, in the first cycle that shows new faces. Faces and LEDs hold their values until the next accepted roll.
- R8: A request that arrives while a roll is in progress, including the done cycle, is ignored. It starts no further roll and does not change the random sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| roll_req | input | 1 | Synchronised one-cycle roll request |
| faces_o | output | 9 | Three face values 1..6, die 0 in the low bits |
| leds_o | output | 21 | Three seven-LED pip patterns, die 0 in the low bits |
| done_o | output | 1 | One-cycle pulse when new faces are latched |

## Verification
The bench runs a long series of back-to-back rolls from the reset seed against a bench model of the shift register. This series covers both the single-attempt path and rolls that reject one or more candidates. The latency check tells these two paths apart, and the face and LED comparison checks the base-6 split and the pip table. Some rolls get an extra request in the middle of shifting, and others get one in the done cycle. For those rolls the sequence must continue unchanged, which shows the extra request did not restart or add a roll. A reset applied in the middle of a roll must clear the outputs and restart the sequence from the seed.

// File: rtl/dice_pkg.sv
package dice_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_CHECK,
      ST_SHOW
   } roll_state_e;

   // Pip order {TL,TR,ML,C,MR,BL,BR}, TL in bit 6; face 0 means dark
   function automatic logic [6:0] pip_pattern(input logic [2:0] face);
      logic [6:0] p;
      case (face)
         3'd1:    p = 7'b0001000;
         3'd2:    p = 7'b1000001;
         3'd3:    p = 7'b1001001;
         3'd4:    p = 7'b1100011;
         3'd5:    p = 7'b1101011;
         3'd6:    p = 7'b1110111;
         default: p = 7'b0000000;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/dice_lfsr.sv
module dice_lfsr #(
   parameter int               WIDTH  = 20,
   parameter int               TAP_HI = 20,
   parameter int               TAP_LO = 17,
   parameter logic [WIDTH-1:0] SEED   = 20'h5A5A5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [WIDTH-1:0] state_o
);

   logic [WIDTH-1:0] q;
   logic             fb;

   assign fb = q[TAP_HI-1] ^ q[TAP_LO-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= SEED;
      end else if (q == '0) begin
         q <= SEED;
      end else if (adv) begin
         q <= {q[WIDTH-2:0], fb};
      end
   end

   assign state_o = q;

endmodule

// File: rtl/dice_ctrl.sv
module dice_ctrl
   import dice_pkg::*;
#(
   parameter int DRAW_W = 8,
   parameter int COMBOS = 216
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              roll_req,
   input  logic [DRAW_W-1:0] cand,
   output logic              adv,
   output logic              accept,
   output logic              done,
   output logic              busy
);

   localparam int              CNT_W = (DRAW_W > 1) ? $clog2(DRAW_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DRAW_W - 1);
   localparam logic [DRAW_W:0]  LIM  = (DRAW_W + 1)'(COMBOS);

   roll_state_e      state;
   logic [CNT_W-1:0] cnt;
   logic             fits;

   assign fits = {1'b0, cand} < LIM;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (roll_req) state <= ST_SHIFT;
            end
            ST_SHIFT: begin
               cnt <= cnt + 1'b1;
               if (cnt == LAST) state <= ST_CHECK;
            end
            ST_CHECK: begin
               cnt   <= '0;
               state <= fits ? ST_SHOW : ST_SHIFT;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign adv    = (state == ST_SHIFT);
   assign accept = (state == ST_CHECK) && fits;
   assign done   = (state == ST_SHOW);
   assign busy   = (state != ST_IDLE);

endmodule

// File: rtl/dice_faces.sv
module dice_faces
   import dice_pkg::*;
#(
   parameter int NUM_DICE = 3,
   parameter int FACES    = 6,
   parameter int DRAW_W   = 8,
   parameter int FACE_W   = 3,
   parameter int PIP_W    = 7
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       load,
   input  logic [DRAW_W-1:0]          value,
   output logic [NUM_DICE*FACE_W-1:0] faces_o,
   output logic [NUM_DICE*PIP_W-1:0]  leds_o
);

   logic [DRAW_W-1:0] quot [NUM_DICE];

   assign quot[0] = value;

   for (genvar i = 0; i < NUM_DICE; i++) begin : g_die
      logic [FACE_W-1:0] digit;
      logic [FACE_W-1:0] face_q;

      assign digit = FACE_W'(quot[i] % DRAW_W'(FACES)) + FACE_W'(1);

      if (i < NUM_DICE - 1) begin : g_next
         assign quot[i+1] = quot[i] / DRAW_W'(FACES);
      end

      always_ff @(posedge clk) begin
         if (rst)       face_q <= '0;
         else if (load) face_q <= digit;
      end

      assign faces_o[i*FACE_W +: FACE_W] = face_q;
      assign leds_o[i*PIP_W +: PIP_W]    = pip_pattern(3'(face_q));
   end

endmodule

// File: rtl/dice_roller.sv
module dice_roller #(
   parameter int                 LFSR_W   = 20,
   parameter int                 TAP_HI   = 20,
   parameter int                 TAP_LO   = 17,
   parameter logic [LFSR_W-1:0]  SEED     = 20'h5A5A5,
   parameter int                 DRAW_W   = 8,
   parameter int                 FACES    = 6,
   parameter int                 NUM_DICE = 3
) (
   input  logic                                    clk,
   input  logic                                    rst,
   input  logic                                    roll_req,
   output logic [NUM_DICE*$clog2(FACES+1)-1:0]     faces_o,
   output logic [NUM_DICE*7-1:0]                   leds_o,
   output logic                                    done_o
);

   localparam int COMBOS = FACES ** NUM_DICE;
   localparam int FACE_W = $clog2(FACES + 1);
   localparam int PIP_W  = 7;

   if (COMBOS > (1 << DRAW_W)) begin : g_err_draw
      $error("draw width too small for the number of combinations");
   end
   if (FACES != 6) begin : g_err_faces
      $error("pip decoding is defined for six faces only");
   end
   if (DRAW_W > LFSR_W || TAP_HI > LFSR_W || TAP_LO >= TAP_HI || TAP_LO < 1) begin : g_err_taps
      $error("shift register taps or draw width out of range");
   end
   if (SEED == '0) begin : g_err_seed
      $error("seed must be nonzero");
   end

   logic [LFSR_W-1:0] lfsr_state;
   logic [DRAW_W-1:0] cand;
   logic              adv;
   logic              accept;
   logic              busy;

   assign cand = lfsr_state[LFSR_W-1 -: DRAW_W];

   dice_lfsr #(
      .WIDTH  (LFSR_W),
      .TAP_HI (TAP_HI),
      .TAP_LO (TAP_LO),
      .SEED   (SEED)
   ) u_lfsr (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .state_o (lfsr_state)
   );

   dice_ctrl #(
      .DRAW_W (DRAW_W),
      .COMBOS (COMBOS)
   ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .roll_req (roll_req),
      .cand     (cand),
      .adv      (adv),
      .accept   (accept),
      .done     (done_o),
      .busy     (busy)
   );

   dice_faces #(
      .NUM_DICE (NUM_DICE),
      .FACES    (FACES),
      .DRAW_W   (DRAW_W),
      .FACE_W   (FACE_W),
      .PIP_W    (PIP_W)
   ) u_faces (
      .clk     (clk),
      .rst     (rst),
      .load    (accept),
      .value   (cand),
      .faces_o (faces_o),
      .leds_o  (leds_o)
   );

endmodule

// File: rtl/dice_roller_chk.sv
module dice_roller_chk #(
   parameter int LFSR_W   = 20,
   parameter int NUM_DICE = 3,
   parameter int FACE_W   = 3
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       done_o,
   input logic                       busy,
   input logic [NUM_DICE*FACE_W-1:0] faces_o,
   input logic [LFSR_W-1:0]          lfsr_state
);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);  // R7

   AST_FACES_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!done_o && !$past(rst)) |-> $stable(faces_o));  // R7

   AST_SHOW_RETURNS_IDLE: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !busy);  // R8

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
      lfsr_state != '0);  // R2

   for (genvar i = 0; i < NUM_DICE; i++) begin : g_rng
      AST_FACE_LEGAL: assert property (@(posedge clk) disable iff (rst)
         done_o |-> (faces_o[i*FACE_W +: FACE_W] >= FACE_W'(1) &&
                     faces_o[i*FACE_W +: FACE_W] <= FACE_W'(6)));  // R5
   end

endmodule

bind dice_roller dice_roller_chk #(
   .LFSR_W   (LFSR_W),
   .NUM_DICE (NUM_DICE),
   .FACE_W   (FACE_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .done_o     (done_o),
   .busy       (busy),
   .faces_o    (faces_o),
   .lfsr_state (lfsr_state)
);

// File: tb/dice_roller_test.sv
module dice_roller_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        roll_req = 1'b0;
   logic [8:0]  faces_o;
   logic [20:0] leds_o;
   logic        done_o;

   always #2 clk = ~clk;

   dice_roller uut (
      .clk      (clk),
      .rst      (rst),
      .roll_req (roll_req),
      .faces_o  (faces_o),
      .leds_o   (leds_o),
      .done_o   (done_o)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   typedef struct packed {
      logic [8:0]  faces;
      logic [20:0] leds;
   } exp_t;

   exp_t        expq[$];
   logic [19:0] mdl;
   int          total_rej = 0;

   function automatic logic [19:0] step(input logic [19:0] s);
      return {s[18:0], s[19] ^ s[16]};
   endfunction

   function automatic logic [6:0] pips(input int f);
      case (f)
         1: return 7'b0001000;
         2: return 7'b1000001;
         3: return 7'b1001001;
         4: return 7'b1100011;
         5: return 7'b1101011;
         6: return 7'b1110111;
         default: return 7'b0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // Driver side of the scoreboard: advance the model and queue the result
   task automatic predict(output int rej);
      int   v;
      int   q;
      exp_t e;
      rej = 0;
      forever begin
         for (int s = 0; s < 8; s++) mdl = step(mdl);
         v = int'(mdl[19:12]);
         if (v <= 215) break;
         rej++;
      end
      q = v;
      for (int i = 0; i < 3; i++) begin
         e.faces[i*3 +: 3] = 3'((q % 6) + 1);
         e.leds[i*7 +: 7]  = pips((q % 6) + 1);
         q = q / 6;
      end
      expq.push_back(e);
   endtask

   // poke > 0: extra request at that negedge during shifting; -1: in done cycle
   task automatic do_roll(input int poke);
      int         rej;
      int         n;
      int         extra;
      logic [8:0] held;
      predict(rej);
      total_rej += rej;
      @(negedge clk) roll_req = 1'b1;
      @(negedge clk) roll_req = 1'b0;
      n = 1;
      while (!done_o && n < 2000) begin
         @(negedge clk);
         n++;
         roll_req = (n == poke);
      end
      check(n == 10 + 9 * rej, "R4", "request to done latency", n, 10 + 9 * rej);
      if (poke == -1) roll_req = 1'b1;
      @(negedge clk);
      roll_req = 1'b0;
      check(done_o == 1'b0, "R7", "done lasts one cycle", done_o, 0);
      held  = faces_o;
      extra = 0;
      for (int c = 0; c < 25; c++) begin
         @(negedge clk);
         if (done_o) extra++;
      end
      check(extra == 0, "R8", "no roll from ignored request", extra, 0);
      check(faces_o == held, "R7", "faces hold between rolls", faces_o, held);
   endtask

   // Monitor side of the scoreboard
   always @(negedge clk) begin
      if (!rst && done_o) begin
         if (expq.size() == 0) begin
            check(1'b0, "R7", "done without pending roll", 1, 0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check(faces_o == e.faces, "R5", "faces (R2 R3 sequence)", faces_o, e.faces);
            check(leds_o == e.leds, "R6", "pip patterns", leds_o, e.leds);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R4 watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      mdl = 20'h5A5A5;
      repeat (3) @(negedge clk);
      check(faces_o == 9'd0 && leds_o == 21'd0 && done_o == 1'b0, "R1",
            "outputs during reset", {faces_o, done_o}, 0);
      rst = 1'b0;
      @(negedge clk);
      check(faces_o == 9'd0, "R1", "faces after reset", faces_o, 0);
      check(leds_o == 21'd0, "R1", "leds after reset", leds_o, 0);
      check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
      repeat (20) @(negedge clk);
      check(done_o == 1'b0 && faces_o == 9'd0, "R1", "idle without request",
            {faces_o, done_o}, 0);

      for (int k = 0; k < 200; k++) begin
         if (k >= 30 && total_rej >= 2) break;
         do_roll((k % 3 == 1) ? 4 : ((k % 3 == 2) ? -1 : 0));
      end
      check(total_rej >= 2, "R4", "rejection path exercised", total_rej, 2);

      // Reset in the middle of an attempt restarts from the seed
      @(negedge clk) roll_req = 1'b1;
      @(negedge clk) roll_req = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(faces_o == 9'd0 && leds_o == 21'd0 && done_o == 1'b0, "R1",
            "outputs after mid-roll reset", {faces_o, done_o}, 0);
      mdl = 20'h5A5A5;
      do_roll(0);
      do_roll(0);
      check(expq.size() == 0, "R7", "every roll reported once", expq.size(), 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule